// File: doc/BRIEF.md
# Power Mode Controller

This block decides when an 8051-class microcontroller core runs, idles or sleeps. Software writes a small power control register. One bit requests idle and one requests power-down. Two general flag bits are kept across an idle period, so that an interrupt handler can tell whether it woke the core. From the current mode the block produces:

- clock enables for the CPU and for the peripherals;
- an oscillator enable;
- an internal reset for the core;
- the levels forced onto the bus strobes and onto ports 0 and 2 while the core sleeps.

The two low-power modes leave by different routes. Idle ends on any enabled interrupt request, or on a reset pin pulse that is long enough. Power-down stops the oscillator, and only the reset pin ends it. After that pin event, the internal reset stays high until the oscillator reports that it is stable. In the normal running mode the strobe and port outputs pass the core's own values through unchanged.

Top module: `pwrmode_ctrl`

## Requirements
- R1: `mode_o` encodes RUN=0, IDLE=1, PDOWN=2, WAKE=3. In RUN, a register write with data bit 1 set enters PDOWN on the next cycle, even when bit 0 is also set. A write with only bit 0 of the pair set enters IDLE.
- R2: In IDLE, `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1.
- R3: In IDLE, a request on any bit of `irq_req` returns the block to RUN on the next cycle. Bit 0 of `pcon_rdata` clears, and the flag bits 3:2 keep their values.
- R4: In RUN or IDLE, a pulse on `rst_pin` shorter than 24 clock cycles changes nothing. A pulse held beyond 24 cycles plus the two-stage synchronizer raises `cpu_rst`, returns the block to RUN and clears `pcon_rdata`.
- R5: In PDOWN, `osc_en`, `cpu_clk_en` and `per_clk_en` are all 0, and `irq_req` has no effect on the mode.
- R6: In PDOWN, `rst_pin` moves the block to WAKE, where `osc_en`=1 and `cpu_rst`=1. WAKE returns to RUN, with `pcon_rdata` cleared, only once `osc_stable`=1 and `rst_pin` is low.
- R7: `ale_o` and `psen_o` are 1 in IDLE and 0 in PDOWN. In RUN and WAKE they follow `ale_norm` and `psen_norm`.
- R8: In IDLE or PDOWN, port 0 drives `p0_sfr` with `p0_oe`=1 when `ext_code`=0, and floats with `p0_oe`=0 when `ext_code`=1. Otherwise it follows `p0_norm` and `p0_oe_norm`.
- R9: `p2_o` shows `addr_hi` in IDLE with `ext_code`=1, and `p2_sfr` in every other IDLE or PDOWN case. In RUN and WAKE it shows `p2_norm`.
- R10: `pcon_rdata` carries the idle mode in bit 0, power-down in bit 1 and the flags in bits 3:2, and reads 0 in bits 7:4. A RUN write loads the flags from data bits 3:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Power-on reset of the block, active low |
| rst_pin | input | 1 | External hardware reset pin, active high, asynchronous |
| osc_stable | input | 1 | Oscillator has settled |
| ext_code | input | 1 | Core fetches from external program memory |
| pcon_we | input | 1 | Power control register write strobe |
| pcon_wdata | input | 8 | Power control register write data |
| irq_req | input | IRQ_W | Enabled interrupt requests |
| ale_norm | input | 1 | Address latch strobe from the core |
| psen_norm | input | 1 | Program store strobe from the core |
| p0_norm | input | PORT_W | Port 0 value from the core |
| p0_oe_norm | input | 1 | Port 0 drive enable from the core |
| p2_norm | input | PORT_W | Port 2 value from the core |
| p0_sfr | input | PORT_W | Port 0 latch contents |
| p2_sfr | input | PORT_W | Port 2 latch contents |
| addr_hi | input | PORT_W | Upper program address byte |
| pcon_rdata | output | 8 | Power control register read value |
| mode_o | output | 2 | Current power mode |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral and interrupt clock enable |
| osc_en | output | 1 | Oscillator enable |
| cpu_rst | output | 1 | Qualified reset to core and registers |
| ale_o | output | 1 | Address latch strobe to pad |
| psen_o | output | 1 | Program store strobe to pad |
| p0_o | output | PORT_W | Port 0 value to pad |
| p0_oe | output | 1 | Port 0 drive enable to pad |
| p2_o | output | PORT_W | Port 2 value to pad |

## Verification
A wrong mode state reaches `mode_o` and the clock enables in the cycle after the register write or the interrupt. The strobe and port levels flip in that same cycle, so a stuck or misrouted mode is visible one clock after its cause. A reset qualifier that counts wrongly shows up only at the end of a pulse: `cpu_rst` rises after a short pulse, or stays low after a long one, about 26 cycles after the pin rises. A stuck wake condition keeps `cpu_rst` high and `mode_o` at 3 after `osc_stable` has risen.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_IDLE = 2'd1,
      PM_DOWN = 2'd2,
      PM_WAKE = 2'd3
   } pm_state_e;

   localparam int PCON_W   = 8;
   localparam int IDLE_BIT = 0;   // lowest mode bit requests idle
   localparam int DOWN_BIT = 1;   // next bit requests power-down
   localparam int FLAG_LO  = 2;
   localparam int FLAG_N   = 2;

endpackage

// File: rtl/pwrmode_rstflt.sv
// Synchronizes the reset pin and qualifies it by a minimum hold time.
module pwrmode_rstflt #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_HOLD    = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic pin_sync,
   output logic qual
);
   localparam int CNT_W = $clog2(MIN_HOLD + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_HOLD);

   logic [SYNC_STAGES:0] chain;
   logic [CNT_W-1:0]     cnt;

   assign chain[0] = pin;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s+1] <= 1'b0;
         else        chain[s+1] <= chain[s];
      end
   end

   assign pin_sync = chain[SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!pin_sync)     cnt <= '0;
      else if (cnt != CNT_TOP) cnt <= cnt + CNT_W'(1);
   end

   assign qual = pin_sync && (cnt == CNT_TOP);

endmodule

// File: rtl/pwrmode_fsm.sv
// Mode sequencing and general flag storage.
module pwrmode_fsm
   import pwrmode_pkg::*;
#(
   parameter int IRQ_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PCON_W-1:0] wr_data,
   input  logic [IRQ_W-1:0]  irq,
   input  logic              rst_qual,
   input  logic              rst_sync,
   input  logic              osc_stable,
   output pm_state_e         state,
   output logic [PCON_W-1:0] pcon
);
   pm_state_e         st_q, st_d;
   logic [FLAG_N-1:0] fl_q, fl_d;
   logic              wake_any;
   logic              unused_wr;

   assign wake_any  = |irq;
   assign unused_wr = ^wr_data;

   always_comb begin
      st_d = st_q;
      fl_d = fl_q;
      case (st_q)
         PM_RUN: begin
            if (rst_qual) begin
               fl_d = '0;
            end else if (wr_en) begin
               fl_d = wr_data[FLAG_LO +: FLAG_N];
               if (wr_data[DOWN_BIT])      st_d = PM_DOWN;
               else if (wr_data[IDLE_BIT]) st_d = PM_IDLE;
            end
         end
         PM_IDLE: begin
            if (rst_qual) begin
               st_d = PM_RUN;
               fl_d = '0;
            end else if (wake_any) begin
               st_d = PM_RUN;
            end
         end
         PM_DOWN: begin
            if (rst_sync) begin
               st_d = PM_WAKE;
               fl_d = '0;
            end
         end
         PM_WAKE: begin
            fl_d = '0;
            if (osc_stable && !rst_sync) st_d = PM_RUN;
         end
         default: st_d = PM_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= PM_RUN;
         fl_q <= '0;
      end else begin
         st_q <= st_d;
         fl_q <= fl_d;
      end
   end

   always_comb begin
      pcon                      = '0;
      pcon[IDLE_BIT]            = (st_q == PM_IDLE);
      pcon[DOWN_BIT]            = (st_q == PM_DOWN);
      pcon[FLAG_LO +: FLAG_N]   = fl_q;
   end

   assign state = st_q;

endmodule

// File: rtl/pwrmode_pinmux.sv
// Forced pad levels while the core sleeps.
module pwrmode_pinmux #(
   parameter int PORT_W = 8
) (
   input  logic              in_idle,
   input  logic              in_down,
   input  logic              ext_code,
   input  logic              ale_norm,
   input  logic              psen_norm,
   input  logic [PORT_W-1:0] p0_norm,
   input  logic              p0_oe_norm,
   input  logic [PORT_W-1:0] p2_norm,
   input  logic [PORT_W-1:0] p0_sfr,
   input  logic [PORT_W-1:0] p2_sfr,
   input  logic [PORT_W-1:0] addr_hi,
   output logic              ale_o,
   output logic              psen_o,
   output logic [PORT_W-1:0] p0_o,
   output logic              p0_oe,
   output logic [PORT_W-1:0] p2_o
);
   logic lp, p0_float, p2_addr;

   assign lp       = in_idle | in_down;
   assign p0_float = lp & ext_code;
   assign p2_addr  = in_idle & ext_code;

   assign ale_o  = lp ? in_idle : ale_norm;
   assign psen_o = lp ? in_idle : psen_norm;
   assign p0_oe  = lp ? !ext_code : p0_oe_norm;

   for (genvar b = 0; b < PORT_W; b++) begin : g_bit
      assign p0_o[b] = !lp      ? p0_norm[b] :
                       p0_float ? 1'b0       : p0_sfr[b];
      assign p2_o[b] = !lp      ? p2_norm[b] :
                       p2_addr  ? addr_hi[b] : p2_sfr[b];
   end

endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
   import pwrmode_pkg::*;
#(
   parameter int MC_CLKS     = 12,
   parameter int RST_MC      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int PORT_W      = 8,
   parameter int IRQ_W       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_pin,
   input  logic              osc_stable,
   input  logic              ext_code,
   input  logic              pcon_we,
   input  logic [7:0]        pcon_wdata,
   input  logic [IRQ_W-1:0]  irq_req,
   input  logic              ale_norm,
   input  logic              psen_norm,
   input  logic [PORT_W-1:0] p0_norm,
   input  logic              p0_oe_norm,
   input  logic [PORT_W-1:0] p2_norm,
   input  logic [PORT_W-1:0] p0_sfr,
   input  logic [PORT_W-1:0] p2_sfr,
   input  logic [PORT_W-1:0] addr_hi,
   output logic [7:0]        pcon_rdata,
   output logic [1:0]        mode_o,
   output logic              cpu_clk_en,
   output logic              per_clk_en,
   output logic              osc_en,
   output logic              cpu_rst,
   output logic              ale_o,
   output logic              psen_o,
   output logic [PORT_W-1:0] p0_o,
   output logic              p0_oe,
   output logic [PORT_W-1:0] p2_o
);
   localparam int MIN_HOLD = MC_CLKS * RST_MC;

   if (MC_CLKS < 1 || RST_MC < 1 || PORT_W < 1 || IRQ_W < 1 || SYNC_STAGES < 0)
   begin : g_bad_param
      initial $fatal(1, "pwrmode_ctrl: illegal parameter value");
   end
   if (PCON_W != 8 || FLAG_LO + FLAG_N > PCON_W) begin : g_bad_layout
      initial $fatal(1, "pwrmode_ctrl: register layout mismatch");
   end

   logic      rst_sync, rst_qual;
   pm_state_e state;
   logic      in_run, in_idle, in_down, in_wake;

   pwrmode_rstflt #(
      .SYNC_STAGES (SYNC_STAGES),
      .MIN_HOLD    (MIN_HOLD)
   ) u_rstflt (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (rst_pin),
      .pin_sync (rst_sync),
      .qual     (rst_qual)
   );

   pwrmode_fsm #(
      .IRQ_W (IRQ_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (pcon_we),
      .wr_data    (pcon_wdata),
      .irq        (irq_req),
      .rst_qual   (rst_qual),
      .rst_sync   (rst_sync),
      .osc_stable (osc_stable),
      .state      (state),
      .pcon       (pcon_rdata)
   );

   assign in_run  = (state == PM_RUN);
   assign in_idle = (state == PM_IDLE);
   assign in_down = (state == PM_DOWN);
   assign in_wake = (state == PM_WAKE);

   assign mode_o     = state;
   assign cpu_rst    = rst_qual | in_wake;
   assign osc_en     = !in_down;
   assign cpu_clk_en = in_run | (in_wake & osc_stable);
   assign per_clk_en = in_run | in_idle | (in_wake & osc_stable);

   pwrmode_pinmux #(
      .PORT_W (PORT_W)
   ) u_pinmux (
      .in_idle    (in_idle),
      .in_down    (in_down),
      .ext_code   (ext_code),
      .ale_norm   (ale_norm),
      .psen_norm  (psen_norm),
      .p0_norm    (p0_norm),
      .p0_oe_norm (p0_oe_norm),
      .p2_norm    (p2_norm),
      .p0_sfr     (p0_sfr),
      .p2_sfr     (p2_sfr),
      .addr_hi    (addr_hi),
      .ale_o      (ale_o),
      .psen_o     (psen_o),
      .p0_o       (p0_o),
      .p0_oe      (p0_oe),
      .p2_o       (p2_o)
   );

endmodule

// File: rtl/pwrmode_ctrl_chk.sv
module pwrmode_ctrl_chk #(
   parameter int IRQ_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic             pcon_we,
   input logic [7:0]       pcon_wdata,
   input logic [7:0]       pcon_rdata,
   input logic [IRQ_W-1:0] irq,
   input logic             osc_stable,
   input logic             cpu_rst,
   input logic             cpu_clk_en,
   input logic             per_clk_en,
   input logic             osc_en,
   input logic             ale_o,
   input logic             psen_o
);
   assert_down_prio_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && pcon_we && pcon_wdata[1] && !cpu_rst) |=> mode == 2'd2);

   assert_idle_clocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'd1 |-> (!cpu_clk_en && per_clk_en && osc_en));

   assert_idle_wake_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1 && (|irq) && !cpu_rst) |=>
         (mode == 2'd0 && pcon_rdata[3:2] == $past(pcon_rdata[3:2])));

   assert_down_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'd2 |-> (!osc_en && !cpu_clk_en && !per_clk_en));

   assert_down_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'd2 |=> (mode == 2'd2 || mode == 2'd3));

   assert_wake_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3 && !osc_stable) |-> cpu_rst);

   assert_strobe_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'd1 |-> (ale_o && psen_o));

   assert_strobe_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mode == 2'd2 |-> (!ale_o && !psen_o));
endmodule

bind pwrmode_ctrl pwrmode_ctrl_chk #(.IRQ_W(IRQ_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (mode_o),
   .pcon_we    (pcon_we),
   .pcon_wdata (pcon_wdata),
   .pcon_rdata (pcon_rdata),
   .irq        (irq_req),
   .osc_stable (osc_stable),
   .cpu_rst    (cpu_rst),
   .cpu_clk_en (cpu_clk_en),
   .per_clk_en (per_clk_en),
   .osc_en     (osc_en),
   .ale_o      (ale_o),
   .psen_o     (psen_o)
);

// File: tb/pwrmode_ctrl_test.sv
module pwrmode_ctrl_test;
   localparam int PW = 8;
   localparam int IW = 5;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n, rst_pin, osc_stable, ext_code, pcon_we;
   logic [7:0]    pcon_wdata;
   logic [IW-1:0] irq_req;
   logic          ale_norm, psen_norm, p0_oe_norm;
   logic [PW-1:0] p0_norm, p2_norm, p0_sfr, p2_sfr, addr_hi;
   logic [7:0]    pcon_rdata;
   logic [1:0]    mode_o;
   logic          cpu_clk_en, per_clk_en, osc_en, cpu_rst, ale_o, psen_o, p0_oe;
   logic [PW-1:0] p0_o, p2_o;

   pwrmode_ctrl uut (
      .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .osc_stable(osc_stable),
      .ext_code(ext_code), .pcon_we(pcon_we), .pcon_wdata(pcon_wdata),
      .irq_req(irq_req), .ale_norm(ale_norm), .psen_norm(psen_norm),
      .p0_norm(p0_norm), .p0_oe_norm(p0_oe_norm), .p2_norm(p2_norm),
      .p0_sfr(p0_sfr), .p2_sfr(p2_sfr), .addr_hi(addr_hi),
      .pcon_rdata(pcon_rdata), .mode_o(mode_o), .cpu_clk_en(cpu_clk_en),
      .per_clk_en(per_clk_en), .osc_en(osc_en), .cpu_rst(cpu_rst),
      .ale_o(ale_o), .psen_o(psen_o), .p0_o(p0_o), .p0_oe(p0_oe), .p2_o(p2_o)
   );

   int total = 0;
   int bad   = 0;

   // {wdata[7:0], ext, mode[1:0], strobe level, p0 drive, p2 shows address}
   localparam logic [13:0] VEC [8] = '{
      {8'h01, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0},
      {8'hF1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1},
      {8'h02, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0},
      {8'h02, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0},
      {8'h03, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0},
      {8'h03, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0},
      {8'h0D, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1},
      {8'h0E, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      pcon_we = 1'b1; pcon_wdata = d;
      @(negedge clk);
      pcon_we = 1'b0;
   endtask

   task automatic go_run();
      osc_stable = 1'b1; rst_pin = 1'b1;
      cyc(40);
      rst_pin = 1'b0;
      cyc(6);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; rst_pin = 1'b0; osc_stable = 1'b1; ext_code = 1'b0;
      pcon_we = 1'b0; pcon_wdata = '0; irq_req = '0;
      ale_norm = 1'b0; psen_norm = 1'b1; p0_oe_norm = 1'b0;
      p0_norm = 8'h5A; p2_norm = 8'h99; p0_sfr = 8'hA5; p2_sfr = 8'h3C; addr_hi = 8'hC3;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);

      // reset state and pass-through in RUN
      chk("R1 reset mode", mode_o, 0);
      chk("R10 reset pcon", pcon_rdata, 0);
      chk("R2 reset clocks", {cpu_clk_en, per_clk_en, osc_en, cpu_rst}, 4'b1110);
      chk("R7 run ale", ale_o, ale_norm);
      chk("R7 run psen", psen_o, psen_norm);
      chk("R8 run p0", {p0_oe, p0_o}, {p0_oe_norm, p0_norm});
      chk("R9 run p2", p2_o, p2_norm);

      // table walk over mode requests and program memory source
      for (int i = 0; i < 8; i++) begin
         logic [7:0] wd;
         logic [7:0] ep;
         logic [1:0] em;
         logic       ex, es, eo, ea;
         {wd, ex, em, es, eo, ea} = VEC[i];
         go_run();
         ext_code = ex; ale_norm = !es; psen_norm = !es;
         ep = {4'h0, wd[3:0]};
         if (ep[1]) ep[0] = 1'b0;
         wr(wd);
         chk($sformatf("R1 vec%0d mode", i), mode_o, em);
         chk($sformatf("R10 vec%0d pcon", i), pcon_rdata, ep);
         if (em == 2'd1)
            chk($sformatf("R2 vec%0d clk", i), {cpu_clk_en, per_clk_en, osc_en}, 3'b011);
         else
            chk($sformatf("R5 vec%0d clk", i), {cpu_clk_en, per_clk_en, osc_en}, 3'b000);
         chk($sformatf("R7 vec%0d strobes", i), {ale_o, psen_o}, {es, es});
         chk($sformatf("R8 vec%0d p0oe", i), p0_oe, eo);
         if (eo) chk($sformatf("R8 vec%0d p0", i), p0_o, p0_sfr);
         chk($sformatf("R9 vec%0d p2", i), p2_o, ea ? addr_hi : p2_sfr);
      end

      // R10 flag write in RUN
      go_run();
      ext_code = 1'b0;
      wr(8'h0C);
      chk("R10 flags only", {mode_o, pcon_rdata}, {2'd0, 8'h0C});

      // R3 interrupt wake keeps flags
      wr(8'h09);
      chk("R3 idle entered", mode_o, 1);
      @(negedge clk); irq_req = 5'b00100;
      @(negedge clk); irq_req = '0;
      chk("R3 wake mode", mode_o, 0);
      chk("R3 flags kept", pcon_rdata, 8'h08);

      // R4 short pulse ignored, long pulse honoured
      wr(8'h0D);
      rst_pin = 1'b1; cyc(20); rst_pin = 1'b0; cyc(6);
      chk("R4 short pulse mode", mode_o, 1);
      chk("R4 short pulse pcon", pcon_rdata, 8'h0D);
      chk("R4 short pulse rst", cpu_rst, 0);
      rst_pin = 1'b1; cyc(35);
      chk("R4 long pulse rst", cpu_rst, 1);
      cyc(5); rst_pin = 1'b0; cyc(6);
      chk("R4 long pulse exit", {cpu_rst, mode_o, pcon_rdata}, {1'b0, 2'd0, 8'h00});

      // R5 and R6 power-down entry and exit
      wr(8'h0E);
      osc_stable = 1'b0;
      @(negedge clk); irq_req = 5'b11111;
      cyc(3); irq_req = '0;
      chk("R5 irq ignored", mode_o, 2);
      chk("R5 osc off", osc_en, 0);
      rst_pin = 1'b1; cyc(5);
      chk("R6 wake mode", mode_o, 3);
      chk("R6 wake osc rst", {osc_en, cpu_rst, cpu_clk_en}, 3'b110);
      rst_pin = 1'b0; cyc(6);
      chk("R6 waits for osc", {mode_o, cpu_rst}, {2'd3, 1'b1});
      chk("R7 wake strobes", {ale_o, psen_o}, {ale_norm, psen_norm});
      osc_stable = 1'b1; cyc(2);
      chk("R6 released", {mode_o, cpu_rst, pcon_rdata}, {2'd0, 1'b0, 8'h00});

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule